// File: doc/BRIEF.md
# Bank Command Filter and Queue

This block sits between a shared packet bus and one memory bank. On every bus cycle it looks at the word on the bus. A word marked as a header is a command word. The block decodes that word to decide two things: whether the command is meant for this bank, and how many data words come after it. Only the command words and data words that belong to this bank are written into an input FIFO. Each FIFO entry carries a tag that tells whether it is a command or data. A downstream decoder drains the FIFO in strict arrival order.

The block also raises a hold-off request to the bus arbiter. It does this whenever the free FIFO space is too small for one more command of the longest kind: one header plus four data words. A programmable address window must be written before this bank accepts anything. The bank is chosen by a field of address bits. The width of that field follows from the power-of-two bank count.

Top module: `bcq_filter_queue`

## Requirements
- R1: The command code is the top 4 bits of a header word. The codes and the number of data words after each are: 1 block read (0), 2 block write (4), 3 single write (1), 4 I/O read (0), 5 broadcast I/O write (1). Any other code is never enqueued and claims 0 data words.
- R2: Until the first write of the window registers after reset, no word is enqueued.
- R3: A memory command (code 1, 2 or 3) is accepted only when both of these hold. First, its bank field `addr[BANK_LSB +: log2(NUM_BANKS)]` equals `bank_id`, where addr is header bits [ADDR_W-1:0]. Second, `base <= addr < base + size`.
- R4: An I/O read (code 4) is accepted when its bank field matches, whatever the window says.
- R5: A broadcast I/O write (code 5) is accepted by every configured bank, whatever its address.
- R6: An accepted header enters the FIFO with tag 1, and its data words enter with tag 0. Data words of a rejected command are dropped. So are data words beyond the count the command claims.
- R7: A header that arrives while data words are still owed starts a new command. The remaining owed words are abandoned.
- R8: Entries leave through `out_word`/`out_tag` in the order they were accepted, one per cycle in which `out_valid` and `out_ready` are both high.
- R9: `stop_req` is high exactly when fewer than 5 FIFO entries are free.
- R10: After reset, `out_valid` and `stop_req` are low.
- R11: A word accepted while the FIFO is full, with no pop in the same cycle, is dropped. Queued entries are never overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_id | input | BANK_W | Index of this bank |
| cfg_we | input | 1 | Writes the window registers |
| cfg_base | input | ADDR_W | Window base address |
| cfg_size | input | ADDR_W | Window size |
| bus_valid | input | 1 | Bus word present this cycle |
| bus_hdr | input | 1 | Bus word is a command header |
| bus_word | input | DATA_W | Bus word |
| out_valid | output | 1 | FIFO head is valid |
| out_ready | input | 1 | Downstream takes the head |
| out_tag | output | 1 | 1 = command word, 0 = data word |
| out_word | output | DATA_W | FIFO head word |
| stop_req | output | 1 | Hold-off request to the arbiter |

## Verification
The bench builds the block with a depth of 8, four banks, a bank field at address bit 5 and 16 address bits. With a depth of 8, two back-to-back block writes sent while the consumer stalls fill the FIFO. That makes both the hold-off threshold and the drop-on-full behaviour reachable. With four banks, random addresses hit this bank, miss it, and fall inside and outside the window often enough to cover every accept rule.

// File: rtl/bcq_pkg.sv
`timescale 1ns/1ps
package bcq_pkg;
  typedef enum logic [3:0] {
    OP_BLK_RD = 4'd1,
    OP_BLK_WR = 4'd2,
    OP_ONE_WR = 4'd3,
    OP_IO_RD  = 4'd4,
    OP_IO_BC  = 4'd5
  } op_e;

  localparam int MAX_DATA = 4;
  localparam int CMD_SPAN = 1 + MAX_DATA;

  function automatic logic [2:0] data_words(input logic [3:0] op);
    case (op)
      OP_BLK_WR: return 3'd4;
      OP_ONE_WR: return 3'd1;
      OP_IO_BC:  return 3'd1;
      default:   return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bcq_decode.sv
`timescale 1ns/1ps
module bcq_decode import bcq_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int BANK_LSB  = 5,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_id,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic              bus_valid,
  input  logic              bus_hdr,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output logic              push,
  output logic              push_tag
);
  logic [ADDR_W-1:0] base_q, size_q;
  logic              cfg_done;
  logic [2:0]        rem_q;
  logic              keep_q;
  logic              hdr_fire, dat_fire, bank_ok, hit;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [ADDR_W-1:0] s);
    return (a >= b) && ((a - b) < s);
  endfunction

  generate
    if (NUM_BANKS > 1) begin : g_bank
      assign bank_ok = (addr[BANK_LSB +: BANK_W] == bank_id);
    end else begin : g_single
      logic unused_id;
      assign unused_id = ^bank_id;
      assign bank_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    hdr_fire = bus_valid && bus_hdr;
    dat_fire = bus_valid && !bus_hdr && (rem_q != 3'd0);
    case (op)
      OP_BLK_RD, OP_BLK_WR, OP_ONE_WR: hit = bank_ok && in_window(addr, base_q, size_q);
      OP_IO_RD:                        hit = bank_ok;
      OP_IO_BC:                        hit = 1'b1;
      default:                         hit = 1'b0;
    endcase
    hit      = hit && cfg_done;
    push     = (hdr_fire && hit) || (dat_fire && keep_q);
    push_tag = hdr_fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      size_q   <= '0;
      cfg_done <= 1'b0;
    end else if (cfg_we) begin
      base_q   <= cfg_base;
      size_q   <= cfg_size;
      cfg_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= 3'd0;
      keep_q <= 1'b0;
    end else if (hdr_fire) begin
      rem_q  <= data_words(op);
      keep_q <= hit;
    end else if (dat_fire) begin
      rem_q  <= rem_q - 3'd1;
    end
  end

  assert_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_fire && op == OP_BLK_WR) |=> (rem_q == 3'd4));
  assert_unconf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !push);
  assert_stray_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_hdr && rem_q == 3'd0) |-> !push);
endmodule

// File: rtl/bcq_fifo.sv
`timescale 1ns/1ps
module bcq_fifo #(
  parameter int W     = 65,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             rd_ok, wr_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign rd_ok   = rd_en && (count != '0);
  assign wr_ok   = wr_en && ((count != FULL_AT) || rd_ok);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_AT && wr_en && !rd_en) |=> (count == FULL_AT));
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> (count == $past(count) || count == $past(count) - 1'b1));
endmodule

// File: rtl/bcq_filter_queue.sv
`timescale 1ns/1ps
module bcq_filter_queue import bcq_pkg::*; #(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int BANK_LSB  = 5,
  parameter int DEPTH     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_id,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic              bus_valid,
  input  logic              bus_hdr,
  input  logic [DATA_W-1:0] bus_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_tag,
  output logic [DATA_W-1:0] out_word,
  output logic              stop_req
);
  localparam logic [CNT_W-1:0] STOP_ABOVE = CNT_W'(DEPTH - CMD_SPAN);

  logic             push, push_tag, pop;
  logic [CNT_W-1:0] level;

  bcq_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_LSB(BANK_LSB)) u_decode (
    .clk(clk), .rst_n(rst_n), .bank_id(bank_id),
    .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .bus_valid(bus_valid), .bus_hdr(bus_hdr),
    .op(bus_word[DATA_W-1 -: 4]), .addr(bus_word[ADDR_W-1:0]),
    .push(push), .push_tag(push_tag)
  );

  bcq_fifo #(.W(DATA_W + 1), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push), .wr_data({push_tag, bus_word}),
    .rd_en(pop), .rd_data({out_tag, out_word}),
    .count(level)
  );

  assign out_valid = (level != '0);
  assign pop       = out_valid && out_ready;
  assign stop_req  = (level > STOP_ABOVE);

  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !pop) |=> stop_req);
  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !stop_req));
endmodule

// File: tb/test_bcq_filter_queue.sv
`timescale 1ns/1ps
module test_bcq_filter_queue;
  localparam int DW = 64, AW = 16, NB = 4, BL = 5, DEP = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [1:0]    bank_id = 2'd2;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_size = '0;
  logic          bus_valid = 1'b0, bus_hdr = 1'b0;
  logic [DW-1:0] bus_word = '0;
  logic          out_valid, out_ready = 1'b0, out_tag, stop_req;
  logic [DW-1:0] out_word;

  int total = 0, bad = 0;
  logic [DW:0] mq[$];
  int  m_rem = 0;
  bit  m_keep = 0, m_cfg = 0;
  logic [AW-1:0] m_base = '0, m_size = '0;
  string phase = "R10";

  always #2.5 clk = ~clk;

  bcq_filter_queue #(.DATA_W(DW), .ADDR_W(AW), .NUM_BANKS(NB), .BANK_LSB(BL), .DEPTH(DEP))
    i_bcq_filter_queue (.clk(clk), .rst_n(rst_n), .bank_id(bank_id), .cfg_we(cfg_we),
      .cfg_base(cfg_base), .cfg_size(cfg_size), .bus_valid(bus_valid), .bus_hdr(bus_hdr),
      .bus_word(bus_word), .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
      .out_word(out_word), .stop_req(stop_req));

  function automatic int exp_len(input logic [3:0] op);
    if (op == 4'd2) return 4;
    if (op == 4'd3 || op == 4'd5) return 1;
    return 0;
  endfunction

  function automatic bit exp_take(input logic [3:0] op, input logic [AW-1:0] a);
    bit mine = (a[6:5] == bank_id);
    bit inwin = ({1'b0, a} >= {1'b0, m_base}) && ({1'b0, a} < {1'b0, m_base} + {1'b0, m_size});
    if (!m_cfg) return 0;
    if (op >= 4'd1 && op <= 4'd3) return mine && inwin;
    if (op == 4'd4) return mine;
    return op == 4'd5;
  endfunction

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit h, input logic [DW-1:0] w, input bit rdy);
    int sz;
    bit pop, take;
    @(negedge clk);
    bus_valid = v; bus_hdr = h; bus_word = w; out_ready = rdy;
    #1;
    sz = mq.size();
    check({phase, " valid"}, {{DW{1'b0}}, out_valid}, {{DW{1'b0}}, sz > 0});
    if (sz > 0) check({phase, " R8 head"}, {out_tag, out_word}, mq[0]);
    check({phase, " R9 stop"}, {{DW{1'b0}}, stop_req}, {{DW{1'b0}}, (DEP - sz) < 5});
    pop = rdy && sz > 0;
    take = 0;
    if (v && h) begin
      take = exp_take(w[DW-1 -: 4], w[AW-1:0]);
      m_keep = take; m_rem = exp_len(w[DW-1 -: 4]);
    end else if (v && m_rem > 0) begin
      take = m_keep; m_rem--;
    end
    if (pop) void'(mq.pop_front());
    if (take && (sz < DEP || pop)) mq.push_back({h, w});
    @(posedge clk);
  endtask

  function automatic logic [DW-1:0] hdr(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, {(DW-4-AW){1'b0}}, a};
  endfunction

  task automatic drain(output int n);
    n = 0;
    for (int k = 0; k < 40 && mq.size() > 0; k++) begin
      n++;
      step(0, 0, '0, 1);
    end
  endtask

  task automatic send_cmd(input logic [3:0] op, input logic [AW-1:0] a, input int nd);
    step(1, 1, hdr(op, a), 0);
    for (int k = 0; k < nd; k++) step(1, 0, {$urandom, $urandom}, 0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R10 valid", {{DW{1'b0}}, out_valid}, '0);
    check("R10 stop",  {{DW{1'b0}}, stop_req}, '0);

    phase = "R2";
    send_cmd(4'd1, 16'h0140, 0);
    step(0, 0, '0, 0);
    check("R2 unconfigured", {{DW{1'b0}}, out_valid}, '0);

    @(negedge clk); cfg_we = 1; cfg_base = 16'h0100; cfg_size = 16'h0800;
    @(negedge clk); cfg_we = 0; m_cfg = 1; m_base = 16'h0100; m_size = 16'h0800;

    phase = "R1";
    send_cmd(4'd2, 16'h0140, 4); drain(n); check("R1 block write entries", n, 5);
    phase = "R3";
    send_cmd(4'd2, 16'h0160, 4); send_cmd(4'd2, 16'h0040, 4); send_cmd(4'd1, 16'h0940, 0);
    drain(n); check("R3 rejected entries", n, 0);
    phase = "R4";
    send_cmd(4'd4, 16'h0040, 0); drain(n); check("R4 io read entries", n, 1);
    phase = "R5";
    send_cmd(4'd5, 16'h0020, 1); drain(n); check("R5 broadcast entries", n, 2);
    phase = "R6";
    send_cmd(4'd3, 16'h0140, 4); drain(n); check("R6 single write entries", n, 2);
    phase = "R7";
    send_cmd(4'd2, 16'h0140, 2); send_cmd(4'd4, 16'h0140, 2);
    drain(n); check("R7 cut command entries", n, 4);
    phase = "R1";
    send_cmd(4'hF, 16'h0140, 2); drain(n); check("R1 unknown code entries", n, 0);
    phase = "R11";
    send_cmd(4'd2, 16'h0140, 4); send_cmd(4'd2, 16'h0140, 4);
    #1 check("R9 stop when full", {{DW{1'b0}}, stop_req}, {{DW{1'b0}}, 1'b1});
    drain(n); check("R11 full drop entries", n, 8);

    phase = "R8";
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [3:0] op;
      case ($urandom % 6)
        0: a = 16'h0140; 1: a = 16'h0160; 2: a = 16'h0040;
        3: a = 16'h08C0; 4: a = 16'h0940; default: a = AW'($urandom);
      endcase
      op = ($urandom % 8 == 0) ? 4'($urandom) : 4'(1 + $urandom % 5);
      if ($urandom % 4 == 0) step(1, 1, hdr(op, a), ($urandom % 3) != 0);
      else step(($urandom % 5) != 0, 0, {$urandom, $urandom}, ($urandom % 3) != 0);
    end
    drain(n);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule